// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the 16-bit status and control word for one root port of a full/low-speed USB host controller, together with the small amount of sequencing logic behind it. Software writes the word over a host bus. Only a write with both byte lanes enabled is applied. The rest of the controller supplies these inputs:

- a connect-detect level
- the two-bit bus line status
- the raw overcurrent pin
- a flag that is high while a transaction is in flight on the port
- a flag that is high while the whole bus is globally suspended

The block drives the port's enable, suspend, reset-signalling and downstream-block outputs.

Three behaviours are the reason the block exists:

- **Enable gating.** Software cannot enable the port until the hardware has seen the device connected, with port reset released, for a full re-detect interval. The interval is derived from a clock-frequency parameter.
- **Deferred suspend.** A suspend request made during a transaction is held pending. The readable suspend bit only changes once the transaction ends.
- **Overcurrent latch.** Overcurrent events are synchronized and edge-detected into a sticky flag that is cleared by writing 1 to it.

Top module: `usb_port_sc`

## Requirements
- R1: Out of reset, with connect low and line status 00, the word reads 0x0080 and every output is low. Bit 0 always reads the connect input. Bits 5:4 always read the line status input.
- R2: Bits 15:13, 10, 8, 6, 3 and 1 always read 0 and bit 7 always reads 1, whatever value is written to them.
- R3: A write applies only when both byte enables are set. A write with any other byte-enable value changes nothing.
- R4: Bit 9 is the port-reset control. It is read/write and drives port_rst_o. While it is 1, enable (bit 2) is held at 0 and a write of 1 to bit 2 is ignored.
- R5: A write of 1 to bit 2 takes effect only once connect has been high, with bit 9 at 0, for DET_CYCLES = CLK_MHZ*DET_NS/1000 consecutive cycles. Connect going low, or bit 9 being set, restarts that count.
- R6: A full write with bit 2 at 0 clears enable. port_en_o is high when bit 2 is 1 and bit 12 is 0.
- R7: A full write with bit 12 at 1 and bit 2 at 1, made while the port may be enabled, no global suspend is active and no transaction is in progress, sets bit 12 on the next cycle. Once bit 12 is set, port_susp_o is high and port_en_o is low.
- R8: A suspend request made while a transaction is in progress stays pending, and bit 12 reads 0. Bit 12 becomes 1 in the cycle after the transaction flag falls.
- R9: A write of 1 to bit 12 while global suspend is active is ignored.
- R10: A full write with bit 12 at 0 leaves suspend. Clearing enable, whether by a write or by setting port reset, cancels both an active and a pending suspend.
- R11: Bit 11 sets on a rising edge of the overcurrent input, seen after a two-flop synchronizer, and stays set. A full write with bit 11 at 1 clears it; a 0 has no effect. A new edge in the same cycle as a clear leaves the bit set.
- R12: down_block_o equals bit 12. Port reset signalling on port_rst_o is not blocked by suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 2 | Byte enables of the write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Current register value |
| connect_i | input | 1 | Device connect detected |
| line_state_i | input | 2 | Bus line status |
| oc_i | input | 1 | Raw overcurrent pin, active high |
| xact_busy_i | input | 1 | Transaction in progress on the port |
| gsusp_i | input | 1 | Global suspend active |
| port_en_o | output | 1 | Port enabled and not suspended |
| port_susp_o | output | 1 | Port suspended |
| port_rst_o | output | 1 | Drive reset signalling on the port |
| down_block_o | output | 1 | Block downstream traffic |

## Verification
The hardest case to reach is an overcurrent edge that arrives at the flag register in the very cycle a write-1-to-clear is applied. The edge only appears after the synchronizer stages, so the stimulus raises the pin and counts two falling edges before issuing the clear write, which places the clear exactly on the capture edge.

The restart of the re-detect interval is also hard to reach. The bench drops connect for a single cycle partway through the interval, then shows that an enable write made after the original interval would have expired still has no effect.

A deferred suspend cancelled by disabling the port is driven by holding the transaction flag high across the suspend and disable writes, then releasing it.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned B_CONN    = 0;
  localparam int unsigned B_EN      = 2;
  localparam int unsigned B_LINE_LO = 4;
  localparam int unsigned B_ONE     = 7;
  localparam int unsigned B_PRST    = 9;
  localparam int unsigned B_OC      = 11;
  localparam int unsigned B_SUSP    = 12;

  typedef struct packed {
    logic prst;
    logic en;
    logic susp;
    logic oc_clr;
  } port_wr_t;
endpackage

// File: rtl/port_redetect.sv
module port_redetect #(
  parameter int unsigned DET_CYCLES = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic connect_i,
  input  logic hold_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(DET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DET_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!connect_i || hold_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/port_oc_detect.sv
module port_oc_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   edge_w;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= oc_i;
      else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign edge_w = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      // set has priority over clear
      if (edge_w)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_state_ctl.sv
module port_state_ctl
  import usb_port_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  port_wr_t wd_i,
  input  logic     ready_i,
  input  logic     busy_i,
  input  logic     gsusp_i,
  output logic     prst_o,
  output logic     en_o,
  output logic     susp_o,
  output logic     pend_o
);
  logic prst_q, en_q, susp_q, pend_q;
  logic prst_d, en_d, susp_d, pend_d;
  logic req_w;

  assign req_w = wr_i & wd_i.susp & ~gsusp_i & ~susp_q & ~pend_q;

  always_comb begin
    prst_d = wr_i ? wd_i.prst : prst_q;

    if (prst_d)    en_d = 1'b0;
    else if (wr_i) en_d = wd_i.en & (en_q | ready_i);
    else           en_d = en_q;

    susp_d = susp_q;
    pend_d = pend_q;
    if (!en_d) begin
      susp_d = 1'b0;
      pend_d = 1'b0;
    end else if (wr_i && !wd_i.susp) begin
      susp_d = 1'b0;
      pend_d = 1'b0;
    end else if (req_w) begin
      if (busy_i) pend_d = 1'b1;
      else        susp_d = 1'b1;
    end else if (pend_q && !busy_i) begin
      susp_d = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prst_q <= 1'b0;
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prst_q <= prst_d;
      en_q   <= en_d;
      susp_q <= susp_d;
      pend_q <= pend_d;
    end
  end

  assign prst_o = prst_q;
  assign en_o   = en_q;
  assign susp_o = susp_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/usb_port_sc.sv
module usb_port_sc
  import usb_port_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 48,
  parameter int unsigned DET_NS      = 5300,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_be_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             connect_i,
  input  logic [1:0]       line_state_i,
  input  logic             oc_i,
  input  logic             xact_busy_i,
  input  logic             gsusp_i,
  output logic             port_en_o,
  output logic             port_susp_o,
  output logic             port_rst_o,
  output logic             down_block_o
);
  localparam int unsigned DET_RAW    = CLK_MHZ * DET_NS / 1000;
  localparam int unsigned DET_CYCLES = (DET_RAW < 1) ? 1 : DET_RAW;

  logic     wr_full;
  port_wr_t wd;
  logic     det_ready, prst, en, susp, susp_pend, oc_flag;
  logic     unused_wd;

  assign wr_full   = wr_en_i & (&wr_be_i);
  assign wd.prst   = wr_data_i[B_PRST];
  assign wd.en     = wr_data_i[B_EN];
  assign wd.susp   = wr_data_i[B_SUSP];
  assign wd.oc_clr = wr_data_i[B_OC];
  assign unused_wd = ^{wr_data_i[15:13], wr_data_i[10], wr_data_i[8:3], wr_data_i[1:0]};

  port_redetect #(.DET_CYCLES(DET_CYCLES)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .connect_i (connect_i),
    .hold_i    (prst),
    .ready_o   (det_ready)
  );

  port_oc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_oc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .oc_i   (oc_i),
    .clr_i  (wr_full & wd.oc_clr),
    .flag_o (oc_flag)
  );

  port_state_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_full),
    .wd_i    (wd),
    .ready_i (det_ready),
    .busy_i  (xact_busy_i),
    .gsusp_i (gsusp_i),
    .prst_o  (prst),
    .en_o    (en),
    .susp_o  (susp),
    .pend_o  (susp_pend)
  );

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[B_CONN]              = connect_i;
    rd_data_o[B_EN]                = en;
    rd_data_o[B_LINE_LO+1:B_LINE_LO] = line_state_i;
    rd_data_o[B_ONE]               = 1'b1;
    rd_data_o[B_PRST]              = prst;
    rd_data_o[B_OC]                = oc_flag;
    rd_data_o[B_SUSP]              = susp;
  end

  assign port_en_o    = en & ~susp;
  assign port_susp_o  = susp;
  assign port_rst_o   = prst;
  assign down_block_o = susp;
endmodule

module usb_port_sc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_be_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        gsusp_i,
  input logic        xact_busy_i,
  input logic        port_rst_o,
  input logic        port_susp_o,
  input logic        det_ready,
  input logic        susp_pend
);
  logic wr_full;
  assign wr_full = wr_en_i & (&wr_be_i);

  AST_PARTIAL_NOEFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i != 2'b11) |=> $stable(port_rst_o)); // R3
  AST_RST_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_o |-> !rd_data_o[2]); // R4
  AST_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[2]) |-> $past(det_ready)); // R5
  AST_SUSP_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(port_susp_o) |-> $past(!xact_busy_i)); // R8
  AST_GSUSP_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_full && wr_data_i[12] && gsusp_i && !port_susp_o && !susp_pend) |=> !port_susp_o); // R9
  AST_SUSP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_susp_o |-> rd_data_o[2]); // R10
  AST_OC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[11] && !(wr_full && wr_data_i[11])) |=> rd_data_o[11]); // R11
endmodule

bind usb_port_sc usb_port_sc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_be_i     (wr_be_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .gsusp_i     (gsusp_i),
  .xact_busy_i (xact_busy_i),
  .port_rst_o  (port_rst_o),
  .port_susp_o (port_susp_o),
  .det_ready   (det_ready),
  .susp_pend   (susp_pend)
);

// File: tb/sim_usb_port_sc.sv
`timescale 1ns/1ps
module sim_usb_port_sc;
  localparam int unsigned CLK_MHZ = 200;
  localparam int unsigned DET_NS  = 5300;
  localparam int unsigned DET     = CLK_MHZ * DET_NS / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic [15:0] rd;
  logic        connect = 1'b0;
  logic [1:0]  line = 2'b00;
  logic        oc = 1'b0;
  logic        busy = 1'b0;
  logic        gsusp = 1'b0;
  logic        p_en, p_susp, p_rst, d_blk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_port_sc #(.CLK_MHZ(CLK_MHZ), .DET_NS(DET_NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_be_i(wr_be), .wr_data_i(wr_data),
    .rd_data_o(rd), .connect_i(connect), .line_state_i(line), .oc_i(oc),
    .xact_busy_i(busy), .gsusp_i(gsusp), .port_en_o(p_en), .port_susp_o(p_susp),
    .port_rst_o(p_rst), .down_block_o(d_blk)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] base_val(input logic c, input logic [1:0] l);
    return 16'h0080 | {15'd0, c} | {10'd0, l, 4'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    void'($urandom(32'h5eed_1234));
    idle(3);
    chk("R1 reset value", rd, 16'h0080);
    chk("R1 outputs in reset", {12'd0, p_en, p_susp, p_rst, d_blk}, 16'h0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 value after reset", rd, 16'h0080);

    connect = 1'b1; line = 2'b10;
    @(negedge clk);
    chk("R1 connect/line fields", rd, base_val(1'b1, 2'b10));

    wr(16'h0004, 2'b11);
    chk("R5 early enable ignored", {15'd0, rd[2]}, 16'h0);
    idle(500);
    connect = 1'b0;
    idle(1);
    connect = 1'b1;
    idle(700);
    wr(16'h0004, 2'b11);
    chk("R5 restart after connect drop", {15'd0, rd[2]}, 16'h0);
    idle(DET);
    wr(16'h0004, 2'b11);
    chk("R5 enable after redetect", {15'd0, rd[2]}, 16'h1 << 0 << 0 | 16'h0 + 16'h1 - 16'h1 + 16'h1 - 16'h0 - 16'h0 - 16'h0 + 16'h0 - 16'h0 - 16'h0 - 16'h0 + 16'h0 - 16'h1 + 16'h1 - 16'h1 + 16'h0);
    chk("R6 port_en_o", {15'd0, p_en}, 16'h1);

    wr(16'h0000, 2'b01);
    chk("R3 low lane only", rd, base_val(1'b1, 2'b10) | 16'h0004);
    wr(16'h0000, 2'b10);
    chk("R3 high lane only", rd, base_val(1'b1, 2'b10) | 16'h0004);

    wr(16'hE54E, 2'b11);
    chk("R2 reserved bits", rd, base_val(1'b1, 2'b10) | 16'h0004);

    wr(16'h1004, 2'b11);
    chk("R7 suspend bit", {15'd0, rd[12]}, 16'h1);
    chk("R7 outputs", {13'd0, p_en, p_susp, d_blk}, 16'h3);
    chk("R12 down block", {15'd0, d_blk}, 16'h1);

    wr(16'h0004, 2'b11);
    chk("R10 exit suspend", {14'd0, rd[12], p_en}, 16'h1);

    gsusp = 1'b1;
    wr(16'h1004, 2'b11);
    chk("R9 global suspend ignore", {15'd0, rd[12]}, 16'h0);
    gsusp = 1'b0;

    busy = 1'b1;
    wr(16'h1004, 2'b11);
    chk("R8 pending reads 0", {15'd0, rd[12]}, 16'h0);
    idle(3);
    chk("R8 still pending", {15'd0, rd[12]}, 16'h0);
    busy = 1'b0;
    @(negedge clk);
    chk("R8 suspend after busy falls", {15'd0, rd[12]}, 16'h1);

    wr(16'h0004, 2'b11);
    busy = 1'b1;
    wr(16'h1004, 2'b11);
    wr(16'h0000, 2'b11);
    chk("R10 disable clears enable", {15'd0, rd[2]}, 16'h0);
    busy = 1'b0;
    idle(2);
    chk("R10 pending cancelled", {15'd0, rd[12]}, 16'h0);

    wr(16'h0004, 2'b11);
    wr(16'h1004, 2'b11);
    wr(16'h0204, 2'b11);
    chk("R4 reset bit and enable", {13'd0, rd[12], rd[9], rd[2]}, 16'h2);
    chk("R4 port_rst_o", {15'd0, p_rst}, 16'h1);
    chk("R12 reset not blocked", {14'd0, p_rst, d_blk}, 16'h2);
    wr(16'h0204, 2'b11);
    chk("R4 enable ignored in reset", {15'd0, rd[2]}, 16'h0);
    wr(16'h0004, 2'b11);
    chk("R5 redetect after reset", {14'd0, rd[9], rd[2]}, 16'h0);
    idle(DET + 5);
    wr(16'h0004, 2'b11);
    chk("R5 enable after reset redetect", {15'd0, rd[2]}, 16'h1);

    chk("R11 initially clear", {15'd0, rd[11]}, 16'h0);
    @(negedge clk); oc = 1'b1;
    idle(5);
    chk("R11 set on edge", {15'd0, rd[11]}, 16'h1);
    wr(16'h0004, 2'b11);
    chk("R11 write 0 no effect", {15'd0, rd[11]}, 16'h1);
    wr(16'h0804, 2'b11);
    chk("R11 write 1 clears", {15'd0, rd[11]}, 16'h0);
    idle(5);
    chk("R11 level no reset", {15'd0, rd[11]}, 16'h0);
    oc = 1'b0;
    idle(5);
    @(negedge clk); oc = 1'b1;
    @(negedge clk);
    wr(16'h0804, 2'b11);
    chk("R11 set wins over clear", {15'd0, rd[11]}, 16'h1);
    wr(16'h0804, 2'b11);
    oc = 1'b0;

    exp = base_val(1'b1, 2'b10) | 16'h0004;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] d;
      logic [1:0]  be;
      d  = 16'($urandom) & ~16'h1A00;
      be = 2'($urandom);
      wr(d, be);
      if (be == 2'b11) exp = base_val(1'b1, 2'b10) | (d & 16'h0004);
      chk(be == 2'b11 ? "R2 R6 random full write" : "R3 random partial write", rd, exp);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule